// File: doc/BRIEF.md
# Pending Interrupt Arbiter and Acknowledge

This block looks over a small bank of virtual interrupt list entries and selects the highest-priority interrupt that is pending and may be delivered. Each entry carries a virtual ID, an 8-bit priority, a group bit, separate pending and active bits, a hardware-linked flag and a physical ID. The entry storage sits outside the block and arrives as one flat bus. The same is true of the active-priority tracker, which supplies a running priority, and of the register decode that raises an acknowledge request.

The highest pending choice is presented combinationally at all times. When an acknowledge is requested, the block decides whether the chosen interrupt may be taken by the requesting group, given the priority mask, the running priority and the binary points. One cycle later it returns either the virtual ID or the spurious ID 1023. On a grant it also issues a single write of the updated entry back to the external bank.

Top module: `pend_arb_ack`

## Requirements
- R1: Only entries with index below `used_cnt` are considered. An entry at or above that count never wins, whatever its contents.
- R2: Entry bit layout, from MSB down: vid[37:22], prio[21:14], grp[13], active[12], pending[11], hw[10], pid[9:0]. An entry is a candidate only when pending=1 and active=0. Active-only and active-plus-pending entries are skipped.
- R3: A group-0 entry (grp=0) is skipped while `grp0_en` is 0, and a group-1 entry is skipped while `grp1_en` is 0.
- R4: The search starts from a best priority of 0xFF, and an entry replaces the best only when its priority is strictly lower. A tie keeps the lower index, and priority 0xFF never wins.
- R5: With no candidate, `hp_valid` is 0, `hp_vid` is 1023 and `hp_prio` is 0xFF. An acknowledge then returns 1023 and makes no write.
- R6: An acknowledge is refused (response 1023, no write) when the winner's group differs from `ack_grp`, or when `prio_mask` is less than or equal to the winner's priority.
- R7: An acknowledge is refused when `run_prio` is less than or equal to the winner's preemption level. The preemption level is prio AND (0xFF shifted left by s), where s = `bp0`+1 for group 0 and s = `bp1` for group 1.
- R8: A granted acknowledge returns the winner's vid and writes the entry back with pending cleared. The active bit is set only if vid ≤ 1019, so IDs 8192 and up never become active. All other fields are unchanged.
- R9: `rsp_valid` is high for exactly the one cycle after each clock edge that samples `ack_req` high. `wr_en`, `wr_idx` and `wr_entry` appear in that same cycle, and `wr_en` is 0 on a refusal.
- R10: While reset is held, `rsp_valid` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_bank | input | NUM_ENTRIES*38 | Flat entry bank, entry i at bits [i*38 +: 38] |
| used_cnt | input | 5 | Number of entries in use |
| grp0_en | input | 1 | Group-0 delivery enable |
| grp1_en | input | 1 | Group-1 delivery enable |
| prio_mask | input | 8 | Priority mask value |
| run_prio | input | 8 | Running priority from the active-priority tracker |
| bp0 | input | 3 | Group-0 binary point |
| bp1 | input | 3 | Group-1 binary point |
| ack_req | input | 1 | Acknowledge request strobe |
| ack_grp | input | 1 | Group of the acknowledge request |
| hp_valid | output | 1 | A deliverable pending entry exists |
| hp_idx | output | 4 | Index of the winning entry |
| hp_vid | output | 16 | Winner vid, or 1023 if none |
| hp_prio | output | 8 | Winner priority, or 0xFF if none |
| rsp_valid | output | 1 | Acknowledge response strobe |
| rsp_id | output | 16 | Acknowledged ID or 1023 |
| wr_en | output | 1 | Entry write-back strobe |
| wr_idx | output | 4 | Entry index to write |
| wr_entry | output | 38 | Updated entry contents |

## Verification
The highest pending outputs are combinational, so the bench sets the bank and controls at a falling edge and compares `hp_*` a short delay later, before the next rising edge. The acknowledge path has one register stage. The bench raises `ack_req` at a falling edge, lets one rising edge pass, and then reads `rsp_*` and `wr_*` at the following falling edge. One cycle after that it confirms that `rsp_valid` has dropped. Only a write that was actually granted is applied to the bench's own copy of the bank, so each scan that follows runs against the updated state.

// File: rtl/pend_arb_pkg.sv
// Shared types and constants for the pending interrupt arbiter.
// Assumes an 8-bit priority where a lower value means more urgent.
package pend_arb_pkg;

    localparam int VID_W  = 16;
    localparam int PID_W  = 10;
    localparam int PRIO_W = 8;

    localparam logic [VID_W-1:0]  SPURIOUS_ID = 16'd1023;
    localparam logic [VID_W-1:0]  MAX_SPI_ID  = 16'd1019;
    localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

    // One list entry; the first field sits in the most significant bits.
    typedef struct packed {
        logic [VID_W-1:0]  vid;
        logic [PRIO_W-1:0] prio;
        logic              grp;
        logic              act;
        logic              pend;
        logic              hw;
        logic [PID_W-1:0]  pid;
    } lr_entry_t;

    localparam int ENTRY_W = $bits(lr_entry_t);

    // Preemption level: priority with the subpriority bits cleared.
    function automatic logic [PRIO_W-1:0] pre_level(
        input logic [PRIO_W-1:0] prio,
        input logic              grp,
        input logic [2:0]        bp0,
        input logic [2:0]        bp1
    );
        logic [3:0] shamt;
        shamt = grp ? {1'b0, bp1} : ({1'b0, bp0} + 4'd1);
        return prio & (IDLE_PRIO << shamt);
    endfunction

endpackage

// File: rtl/pa_qualify.sv
// Per-entry qualification: decides whether one list entry may compete.
// Assumes in_use already reflects the used-entry count.
module pa_qualify
    import pend_arb_pkg::*;
(
    input  lr_entry_t entry,
    input  logic      in_use,
    input  logic      grp0_en,
    input  logic      grp1_en,
    output logic      cand
);

    logic state_ok;
    logic grp_ok;

    // Candidate needs pending alone and an enabled group.
    always_comb begin
        state_ok = entry.pend && !entry.act;
        grp_ok   = entry.grp ? grp1_en : grp0_en;
        cand     = in_use && state_ok && grp_ok;
    end

endmodule

// File: rtl/pa_scan.sv
// Linear priority scan: the lowest priority value among candidates wins.
// A strict compare keeps the lower index on ties, and the idle value never wins.
module pa_scan
    import pend_arb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 4
) (
    input  logic [NUM_ENTRIES-1:0]        cand,
    input  logic [NUM_ENTRIES*PRIO_W-1:0] prio_flat,
    output logic                          found,
    output logic [IDX_W-1:0]              win_idx,
    output logic [PRIO_W-1:0]             win_prio
);

    // Walk the entries in index order and keep the strictly better one.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = IDLE_PRIO;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (cand[i] && (prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/pa_accept.sv
// Acknowledge gate: checks group, mask and running priority for the winner
// and forms the entry's new contents. Purely combinational.
module pa_accept
    import pend_arb_pkg::*;
(
    input  lr_entry_t         win,
    input  logic              found,
    input  logic              ack_grp,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic [2:0]        bp0,
    input  logic [2:0]        bp1,
    output logic              grant,
    output lr_entry_t         new_entry
);

    logic [PRIO_W-1:0] win_pre;
    logic              grp_ok;
    logic              mask_ok;
    logic              run_ok;

    // Evaluate the three refusal conditions.
    always_comb begin
        win_pre = pre_level(win.prio, win.grp, bp0, bp1);
        grp_ok  = (win.grp == ack_grp);
        mask_ok = (prio_mask > win.prio);
        run_ok  = (run_prio > win_pre);
        grant   = found && grp_ok && mask_ok && run_ok;
    end

    // Pending is cleared; active is set only for non-message IDs.
    always_comb begin
        new_entry      = win;
        new_entry.pend = 1'b0;
        new_entry.act  = (win.vid <= MAX_SPI_ID);
    end

endmodule

// File: rtl/pend_arb_ack.sv
// Top of the pending interrupt arbiter and acknowledge unit.
// Scans the first used_cnt entries combinationally, shows the best pending
// entry, and registers the acknowledge response and write-back for one cycle.
// Assumes the external bank applies wr_entry on the cycle wr_en is high.
module pend_arb_ack
    import pend_arb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_ENTRIES*ENTRY_W-1:0] ent_bank,
    input  logic [CNT_W-1:0]               used_cnt,
    input  logic                           grp0_en,
    input  logic                           grp1_en,
    input  logic [PRIO_W-1:0]              prio_mask,
    input  logic [PRIO_W-1:0]              run_prio,
    input  logic [2:0]                     bp0,
    input  logic [2:0]                     bp1,
    input  logic                           ack_req,
    input  logic                           ack_grp,
    output logic                           hp_valid,
    output logic [IDX_W-1:0]               hp_idx,
    output logic [VID_W-1:0]               hp_vid,
    output logic [PRIO_W-1:0]              hp_prio,
    output logic                           rsp_valid,
    output logic [VID_W-1:0]               rsp_id,
    output logic                           wr_en,
    output logic [IDX_W-1:0]               wr_idx,
    output logic [ENTRY_W-1:0]             wr_entry
);

    lr_entry_t                     ent [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0]        cand;
    logic [NUM_ENTRIES*PRIO_W-1:0] prio_flat;
    logic                          found;
    logic [IDX_W-1:0]              win_idx;
    logic [PRIO_W-1:0]             win_prio;
    lr_entry_t                     win;
    logic                          grant;
    lr_entry_t                     new_entry;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        logic in_use;
        assign ent[g]  = lr_entry_t'(ent_bank[g*ENTRY_W +: ENTRY_W]);
        assign in_use  = (CNT_W'(g) < used_cnt);
        assign prio_flat[g*PRIO_W +: PRIO_W] = ent[g].prio;

        pa_qualify u_qual (
            .entry   (ent[g]),
            .in_use  (in_use),
            .grp0_en (grp0_en),
            .grp1_en (grp1_en),
            .cand    (cand[g])
        );
    end

    pa_scan #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_scan (
        .cand      (cand),
        .prio_flat (prio_flat),
        .found     (found),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    // Select the winning entry's contents.
    always_comb win = ent[win_idx];

    pa_accept u_acc (
        .win       (win),
        .found     (found),
        .ack_grp   (ack_grp),
        .prio_mask (prio_mask),
        .run_prio  (run_prio),
        .bp0       (bp0),
        .bp1       (bp1),
        .grant     (grant),
        .new_entry (new_entry)
    );

    // Present the highest pending choice, or spurious when none.
    always_comb begin
        hp_valid = found;
        hp_idx   = win_idx;
        hp_vid   = found ? win.vid : SPURIOUS_ID;
        hp_prio  = win_prio;
    end

    // Register the acknowledge response and the entry write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= SPURIOUS_ID;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_entry  <= '0;
        end else begin
            rsp_valid <= ack_req;
            wr_en     <= ack_req && grant;
            if (ack_req) begin
                rsp_id   <= grant ? win.vid : SPURIOUS_ID;
                wr_idx   <= win_idx;
                wr_entry <= new_entry;
            end
        end
    end

endmodule

// File: rtl/pend_arb_ack_chk.sv
// Property checker for pend_arb_ack, attached by bind below.
module pend_arb_ack_chk
    import pend_arb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ack_req,
    input logic [PRIO_W-1:0]  prio_mask,
    input logic               hp_valid,
    input logic [PRIO_W-1:0]  hp_prio,
    input logic               rsp_valid,
    input logic [VID_W-1:0]   rsp_id,
    input logic               wr_en,
    input logic [ENTRY_W-1:0] wr_entry
);

    lr_entry_t wr_view;
    assign wr_view = lr_entry_t'(wr_entry);

    assert_idle_never_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |-> (hp_prio != IDLE_PRIO));

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> rsp_valid);

    assert_wr_only_with_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rsp_valid);

    assert_none_gives_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !hp_valid) |=> (rsp_id == SPURIOUS_ID && !wr_en));

    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && hp_valid && (prio_mask <= hp_prio)) |=> !wr_en);

    assert_wr_id_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rsp_id == wr_view.vid && !wr_view.pend));

    assert_msg_never_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view.vid > MAX_SPI_ID) |-> !wr_view.act);

endmodule

bind pend_arb_ack pend_arb_ack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_req   (ack_req),
    .prio_mask (prio_mask),
    .hp_valid  (hp_valid),
    .hp_prio   (hp_prio),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .wr_en     (wr_en),
    .wr_entry  (wr_entry)
);

// File: tb/sim_pend_arb_ack.sv
module sim_pend_arb_ack;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int EW = 38;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N*EW-1:0]   ent_bank;
    logic [4:0]        used_cnt;
    logic              grp0_en, grp1_en;
    logic [7:0]        prio_mask, run_prio;
    logic [2:0]        bp0, bp1;
    logic              ack_req, ack_grp;
    logic              hp_valid;
    logic [3:0]        hp_idx;
    logic [15:0]       hp_vid;
    logic [7:0]        hp_prio;
    logic              rsp_valid;
    logic [15:0]       rsp_id;
    logic              wr_en;
    logic [3:0]        wr_idx;
    logic [EW-1:0]     wr_entry;

    logic [EW-1:0] bank [N];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) ent_bank[i*EW +: EW] = bank[i];
    end

    pend_arb_ack u0 (
        .clk(clk), .rst_n(rst_n), .ent_bank(ent_bank), .used_cnt(used_cnt),
        .grp0_en(grp0_en), .grp1_en(grp1_en), .prio_mask(prio_mask),
        .run_prio(run_prio), .bp0(bp0), .bp1(bp1), .ack_req(ack_req),
        .ack_grp(ack_grp), .hp_valid(hp_valid), .hp_idx(hp_idx),
        .hp_vid(hp_vid), .hp_prio(hp_prio), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] mk(input logic [15:0] vid, input logic [7:0] prio,
                                         input logic grp, input logic act, input logic pend);
        return {vid, prio, grp, act, pend, 1'b1, 10'h155};
    endfunction

    // Expected winner per R1..R4; returns -1 when none qualifies.
    function automatic int exp_win();
        int w = -1;
        logic [7:0] best = 8'hFF;
        for (int i = 0; i < N; i++) begin
            logic [EW-1:0] e = bank[i];
            logic g = e[13];
            if (i < int'(used_cnt) && e[11] && !e[12] && (g ? grp1_en : grp0_en)
                && e[21:14] < best) begin
                best = e[21:14];
                w = i;
            end
        end
        return w;
    endfunction

    // Expected acceptance per R6, R7.
    function automatic bit exp_grant(input int w);
        logic [7:0] p, pre;
        logic g;
        int s;
        if (w < 0) return 1'b0;
        p = bank[w][21:14];
        g = bank[w][13];
        s = g ? int'(bp1) : int'(bp0) + 1;
        pre = p & 8'(8'hFF << s);
        return (g == ack_grp) && (prio_mask > p) && (run_prio > pre);
    endfunction

    // Check scan outputs, perform one acknowledge, check result, update model.
    task automatic run_case(input string tag);
        int w;
        bit gr;
        logic [EW-1:0] ne;
        #1;
        w  = exp_win();
        gr = exp_grant(w);
        chk({tag, " R4 hp_valid"}, 64'(hp_valid), 64'(w >= 0));
        if (w >= 0) begin
            chk({tag, " R4 hp_idx"}, 64'(hp_idx), 64'(w));
            chk({tag, " R1 hp_vid"}, 64'(hp_vid), 64'(bank[w][37:22]));
        end else begin
            chk({tag, " R5 hp_vid"}, 64'(hp_vid), 64'd1023);
            chk({tag, " R5 hp_prio"}, 64'(hp_prio), 64'hFF);
        end
        ack_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_req = 1'b0;
        chk({tag, " R9 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " R9 wr_en"}, 64'(wr_en), 64'(gr));
        if (gr) begin
            ne = bank[w];
            ne[11] = 1'b0;
            ne[12] = (bank[w][37:22] <= 16'd1019);
            chk({tag, " R8 rsp_id"}, 64'(rsp_id), 64'(bank[w][37:22]));
            chk({tag, " R8 wr_idx"}, 64'(wr_idx), 64'(w));
            chk({tag, " R8 wr_entry"}, 64'(wr_entry), 64'(ne));
            bank[w] = ne;
        end else begin
            chk({tag, " R6 R7 spurious"}, 64'(rsp_id), 64'd1023);
        end
        @(negedge clk);
        chk({tag, " R9 rsp_drop"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic clear_bank();
        for (int i = 0; i < N; i++) bank[i] = '0;
    endtask

    task automatic open_ctrl();
        used_cnt = 5'd16; grp0_en = 1'b1; grp1_en = 1'b1;
        prio_mask = 8'hFF; run_prio = 8'hFF; bp0 = 3'd0; bp1 = 3'd0; ack_grp = 1'b1;
    endtask

    initial begin
        int seed;
        seed = 20240607;
        void'($urandom(seed));
        rst_n = 1'b0; ack_req = 1'b0;
        clear_bank(); open_ctrl();
        repeat (3) @(negedge clk);
        // R10: outputs quiet under reset
        chk("R10 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10 wr_en", 64'(wr_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: empty bank
        run_case("empty R5");

        // R4: tie keeps lower index, 0xFF never wins
        clear_bank(); open_ctrl();
        bank[2] = mk(16'd40, 8'h30, 1'b1, 1'b0, 1'b1);
        bank[5] = mk(16'd50, 8'h30, 1'b1, 1'b0, 1'b1);
        bank[7] = mk(16'd60, 8'hFF, 1'b1, 1'b0, 1'b1);
        run_case("tie R4");
        clear_bank();
        bank[0] = mk(16'd61, 8'hFF, 1'b1, 1'b0, 1'b1);
        run_case("idle prio R4");

        // R2: active and active+pending skipped
        clear_bank();
        bank[0] = mk(16'd70, 8'h10, 1'b1, 1'b1, 1'b1);
        bank[1] = mk(16'd71, 8'h10, 1'b1, 1'b1, 1'b0);
        bank[3] = mk(16'd72, 8'h80, 1'b1, 1'b0, 1'b1);
        run_case("state R2");

        // R1: entry beyond used count ignored
        clear_bank(); used_cnt = 5'd4;
        bank[9] = mk(16'd80, 8'h00, 1'b1, 1'b0, 1'b1);
        bank[3] = mk(16'd81, 8'h90, 1'b1, 1'b0, 1'b1);
        run_case("used R1");
        clear_bank(); used_cnt = 5'd0;
        bank[0] = mk(16'd82, 8'h00, 1'b1, 1'b0, 1'b1);
        run_case("used zero R1");

        // R3: group enables
        clear_bank(); open_ctrl(); grp1_en = 1'b0;
        bank[0] = mk(16'd90, 8'h10, 1'b1, 1'b0, 1'b1);
        bank[1] = mk(16'd91, 8'h40, 1'b0, 1'b0, 1'b1);
        ack_grp = 1'b0;
        run_case("grp enable R3");

        // R6: group mismatch and mask equal to priority
        clear_bank(); open_ctrl();
        bank[0] = mk(16'd100, 8'h40, 1'b0, 1'b0, 1'b1);
        run_case("grp mismatch R6");
        prio_mask = 8'h40; ack_grp = 1'b0;
        run_case("mask equal R6");

        // R7: running priority equal to preemption level, then one above
        clear_bank(); open_ctrl(); bp1 = 3'd4;
        bank[0] = mk(16'd110, 8'h4C, 1'b1, 1'b0, 1'b1);
        run_prio = 8'h40;
        run_case("run equal R7");
        run_prio = 8'h41;
        run_case("run above R7");
        clear_bank(); open_ctrl(); bp0 = 3'd2; ack_grp = 1'b0;
        bank[0] = mk(16'd111, 8'h4C, 1'b0, 1'b0, 1'b1);
        run_prio = 8'h48;
        run_case("grp0 shift R7");

        // R8: vid boundary 1019/1020 and message ID 8192
        clear_bank(); open_ctrl();
        bank[0] = mk(16'd1019, 8'h10, 1'b1, 1'b0, 1'b1);
        bank[1] = mk(16'd1020, 8'h20, 1'b1, 1'b0, 1'b1);
        bank[2] = mk(16'd8192, 8'h30, 1'b1, 1'b0, 1'b1);
        run_case("spi max R8");
        run_case("above spi R8");
        run_case("message R8");

        // Random mix
        for (int t = 0; t < 400; t++) begin
            for (int i = 0; i < N; i++) begin
                logic [31:0] r = $urandom();
                bank[i] = mk(r[15:0] & 16'h23FF, (r[19:16] == 0) ? 8'hFF : 8'($urandom()),
                             r[20], r[21] & r[22], r[23] | r[24]);
            end
            used_cnt  = 5'($urandom_range(0, 16));
            grp0_en   = ($urandom_range(0, 3) != 0);
            grp1_en   = ($urandom_range(0, 3) != 0);
            prio_mask = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom());
            run_prio  = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom());
            bp0       = 3'($urandom());
            bp1       = 3'($urandom());
            ack_grp   = 1'($urandom());
            run_case("random R1 R2 R3");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule